// File: doc/BRIEF.md
# Dual-Pattern Serial Bit Player with Error Insertion

This block plays a stored bit pattern out of a one-bit serial output, one bit per clock. The pattern store holds `2*HALF_DEPTH` bits and is split into two halves. Half A sits at addresses `0..HALF_DEPTH-1` and half B at `HALF_DEPTH..2*HALF_DEPTH-1`. Each half has its own programmable active length, and the read pointer wraps at the end of the active part of whichever half is playing. Software loads the store through a simple single-bit write port.

Two asynchronous external inputs steer the output. Each passes through a two-flop synchronizer, and edges are detected in the output clock domain. The selector input can toggle the playing half on each pulse, pick the half by its level, or blank the data. Which of these it does depends on the selector mode and on whether dual-half mode is on. A half change takes effect only when the current repetition ends. The error input either flips single output bits or, with idle enabled, forces the output into an idle state.

Top module: `pattern_player`

## Requirements
- R1: While `rstN` is low and just after it rises, `dataOut`, `idleOut` and `activeHalf` are 0, and playback starts at address 0 of half A.
- R2: With `altMode`=0 the block plays half A. After a bit position p is read, `dataOut` presents `mem[p]` on the next clock, for p = 0,1,…,`lenA`-1, 0,1,… with no gaps. Valid lengths are 1..`HALF_DEPTH`.
- R3: With `altMode`=1 and `auxMode`=0 (toggle), each rising edge seen on `auxIn` flips the target half.
- R4: With `altMode`=1 and `auxMode`=1 (level), the target half is the synchronized level of `auxIn`: 0 selects half A and 1 selects half B.
- R5: `activeHalf` changes only when a repetition wraps, so a partial pattern is never played. Half B plays addresses `HALF_DEPTH`..`HALF_DEPTH`+`lenB`-1.
- R6: With `altMode`=0 and `auxMode`=2 (blank), a high `auxIn` forces `dataOut` to 0 and keeps `idleOut` at 0. The read pointer keeps advancing meanwhile.
- R7: With `idleEnable`=0, each rising edge on `errAddIn` inverts exactly one output bit, the next one sent.
- R8: An error edge that arrives while data is blanked or idle is held pending. It inverts the first bit sent once output resumes.
- R9: With `idleEnable`=1, a high `errAddIn` sets `idleOut`=1 and forces `dataOut`=0, and a low level restores normal output. No bit errors are inserted in this mode.
- R10: A level change on `errAddIn` or `auxIn` reaches the outputs on the third rising clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Pattern store write strobe |
| wrAddr | input | $clog2(2*HALF_DEPTH) | Pattern store write address |
| wrData | input | 1 | Pattern store write bit |
| altMode | input | 1 | 1 = dual-half mode |
| auxMode | input | 2 | Selector mode: 0 toggle, 1 level, 2 blank, 3 no effect |
| idleEnable | input | 1 | 1 = error input acts as idle control |
| lenA | input | $clog2(HALF_DEPTH+1) | Active length of half A |
| lenB | input | $clog2(HALF_DEPTH+1) | Active length of half B |
| errAddIn | input | 1 | Asynchronous error / idle input |
| auxIn | input | 1 | Asynchronous selector input |
| dataOut | output | 1 | Serial data bit |
| idleOut | output | 1 | Idle state flag |
| activeHalf | output | 1 | Half currently playing |

## Verification
The bench first aims at half switching. It fires selector pulses and level changes in the middle of a repetition. A design that switched at once, or that used the wrong length for the new half, would play a cut-short pattern or read from the wrong address range, and the bit stream would diverge.

It then raises error edges while data is blanked, and again in idle mode. A design that dropped the pending error would lose a flip, and one that flipped while blanked would leave a 1 on a forced-zero output. A design that kept inserting errors in idle mode would flip bits after idle ends.

A directed latency probe counts the edges until `idleOut` responds. It catches a synchronizer that is one flop short or one flop too long.

// File: rtl/pattern_player_pkg.sv
package pattern_player_pkg;

  typedef enum logic [1:0] {
    AUX_TOGGLE = 2'd0,
    AUX_LEVEL  = 2'd1,
    AUX_BLANK  = 2'd2,
    AUX_NONE   = 2'd3
  } auxMode_e;

  typedef struct packed {
    logic sendBit;   // a pattern bit goes out this cycle
    logic flipBit;   // invert the bit going out
    logic idleBit;   // idle state requested
    logic nextHalf;  // half to play after the current repetition
  } ctrlStrobe_t;

endpackage

// File: rtl/pattern_player_sync.sv
module pattern_player_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncLvl,
  output logic [WIDTH-1:0] syncPrev
);

  logic [STAGES:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '0;
    else       pipe <= {pipe[STAGES-1:0], asyncIn};
  end

  assign syncLvl  = pipe[STAGES-1];
  assign syncPrev = pipe[STAGES];

endmodule

// File: rtl/pattern_player_ctrl.sv
module pattern_player_ctrl
  import pattern_player_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        altMode,
  input  logic [1:0]  auxMode,
  input  logic        idleEnable,
  input  logic        errLvl,
  input  logic        errPrev,
  input  logic        auxLvl,
  input  logic        auxPrev,
  output ctrlStrobe_t strobe
);

  auxMode_e modeSel;
  logic errRise, auxRise, idleNow, blankNow, sendNow, errNow;
  logic errPend, targetHalf;

  assign modeSel  = auxMode_e'(auxMode);
  assign errRise  = errLvl & ~errPrev;
  assign auxRise  = auxLvl & ~auxPrev;
  assign idleNow  = idleEnable & errLvl;
  assign blankNow = ~altMode & (modeSel == AUX_BLANK) & auxLvl;
  assign sendNow  = ~idleNow & ~blankNow;
  assign errNow   = ~idleEnable & (errRise | errPend);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errPend    <= 1'b0;
      targetHalf <= 1'b0;
    end else begin
      errPend <= errNow & ~sendNow;
      if (altMode) begin
        if (modeSel == AUX_TOGGLE && auxRise) targetHalf <= ~targetHalf;
        else if (modeSel == AUX_LEVEL)        targetHalf <= auxLvl;
      end
    end
  end

  always_comb begin
    strobe.sendBit  = sendNow;
    strobe.flipBit  = errNow & sendNow;
    strobe.idleBit  = idleNow;
    strobe.nextHalf = altMode & targetHalf;
  end

endmodule

// File: rtl/pattern_player_dp.sv
module pattern_player_dp
  import pattern_player_pkg::*;
#(
  parameter int HALF_DEPTH = 16,
  parameter int POS_W      = 4,
  parameter int LEN_W      = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [POS_W:0]    wrAddr,
  input  logic              wrData,
  input  logic [LEN_W-1:0]  lenA,
  input  logic [LEN_W-1:0]  lenB,
  input  ctrlStrobe_t       strobe,
  output logic              dataOut,
  output logic              idleOut,
  output logic              activeHalf,
  output logic [POS_W-1:0]  posQ
);

  localparam int MEM_BITS = 2 * HALF_DEPTH;

  logic [MEM_BITS-1:0] memBits;
  logic [POS_W-1:0]    pos;
  logic                half;
  logic [LEN_W-1:0]    curLen;
  logic [LEN_W:0]      nextCount;
  logic                lastBit, readBit;

  always_ff @(posedge clk) begin
    if (wrEn) memBits[wrAddr] <= wrData;
  end

  assign readBit   = memBits[{half, pos}];
  assign curLen    = half ? lenB : lenA;
  assign nextCount = {{(LEN_W + 1 - POS_W){1'b0}}, pos} + (LEN_W + 1)'(1);
  assign lastBit   = (nextCount >= {1'b0, curLen}) || (pos == POS_W'(HALF_DEPTH - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pos     <= '0;
      half    <= 1'b0;
      dataOut <= 1'b0;
      idleOut <= 1'b0;
    end else begin
      dataOut <= strobe.sendBit & (readBit ^ strobe.flipBit);
      idleOut <= strobe.idleBit;
      if (lastBit) begin
        pos  <= '0;
        half <= strobe.nextHalf;
      end else begin
        pos  <= pos + POS_W'(1);
      end
    end
  end

  assign activeHalf = half;
  assign posQ       = pos;

endmodule

// File: rtl/pattern_player.sv
module pattern_player
  import pattern_player_pkg::*;
#(
  parameter int HALF_DEPTH = 16,
  localparam int POS_W     = $clog2(HALF_DEPTH),
  localparam int LEN_W     = $clog2(HALF_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [POS_W:0]   wrAddr,
  input  logic             wrData,
  input  logic             altMode,
  input  logic [1:0]       auxMode,
  input  logic             idleEnable,
  input  logic [LEN_W-1:0] lenA,
  input  logic [LEN_W-1:0] lenB,
  input  logic             errAddIn,
  input  logic             auxIn,
  output logic             dataOut,
  output logic             idleOut,
  output logic             activeHalf
);

  logic [1:0]  syncLvl, syncPrev;
  ctrlStrobe_t strobe;
  logic [POS_W-1:0] posQ;

  pattern_player_sync #(.WIDTH(2), .STAGES(2)) uSync (
    .clk(clk), .rstN(rstN), .asyncIn({auxIn, errAddIn}),
    .syncLvl(syncLvl), .syncPrev(syncPrev)
  );

  pattern_player_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .altMode(altMode), .auxMode(auxMode),
    .idleEnable(idleEnable),
    .errLvl(syncLvl[0]), .errPrev(syncPrev[0]),
    .auxLvl(syncLvl[1]), .auxPrev(syncPrev[1]),
    .strobe(strobe)
  );

  pattern_player_dp #(.HALF_DEPTH(HALF_DEPTH), .POS_W(POS_W), .LEN_W(LEN_W)) uDp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .lenA(lenA), .lenB(lenB), .strobe(strobe),
    .dataOut(dataOut), .idleOut(idleOut), .activeHalf(activeHalf), .posQ(posQ)
  );

endmodule

// File: rtl/pattern_player_checker.sv
module pattern_player_checker #(
  parameter int POS_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             dataOut,
  input logic             idleOut,
  input logic             activeHalf,
  input logic [POS_W-1:0] posQ,
  input logic             sendBit
);

  // R2: the read pointer steps by one unless it has just wrapped
  a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rstN)
    (posQ != '0) |-> (posQ == $past(posQ) + POS_W'(1)));

  // R5: the playing half only changes together with a wrap to address 0
  a_r5_switch_on_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (activeHalf != $past(activeHalf)) |-> (posQ == '0));

  // R6: a cycle the control marks as not sending leaves a zero on the output
  a_r6_blank_zero: assert property (@(posedge clk) disable iff (!rstN)
    !$past(sendBit) |-> !dataOut);

  // R9: idle never coexists with a driven one
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    idleOut |-> !dataOut);

endmodule

bind pattern_player pattern_player_checker #(.POS_W(POS_W)) uChk (
  .clk(clk), .rstN(rstN), .dataOut(dataOut), .idleOut(idleOut),
  .activeHalf(activeHalf), .posQ(posQ), .sendBit(strobe.sendBit)
);

// File: tb/tb_pattern_player.sv
`timescale 1ns/1ps
module tb_pattern_player;

  localparam int N      = 16;
  localparam int AW     = $clog2(2 * N);
  localparam int LW     = $clog2(N + 1);
  localparam int LEN_A  = 5;
  localparam int LEN_B  = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic wrData = 1'b0;
  logic altMode = 1'b0;
  logic [1:0] auxMode = 2'd0;
  logic idleEnable = 1'b0;
  logic [LW-1:0] lenA = LW'(LEN_A);
  logic [LW-1:0] lenB = LW'(LEN_B);
  logic errAddIn = 1'b0;
  logic auxIn = 1'b0;
  logic dataOut, idleOut, activeHalf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string curReq = "R1";

  always #2 clk = ~clk;

  pattern_player #(.HALF_DEPTH(N)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .altMode(altMode), .auxMode(auxMode), .idleEnable(idleEnable),
    .lenA(lenA), .lenB(lenB), .errAddIn(errAddIn), .auxIn(auxIn),
    .dataOut(dataOut), .idleOut(idleOut), .activeHalf(activeHalf)
  );

  // reference model state
  bit tbMem [2*N];
  bit qErr[$];
  bit qAux[$];
  int mPos, mHalf, mTarget;
  bit mPend, mData, mIdle;

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      qErr = '{0, 0, 0};
      qAux = '{0, 0, 0};
      mPos = 0; mHalf = 0; mTarget = 0;
      mPend = 0; mData = 0; mIdle = 0;
    end else begin
      bit eL, eP, aL, aP, eR, aR, idleNow, blank, send, errNow;
      int len;
      eL = qErr[1]; eP = qErr[2]; aL = qAux[1]; aP = qAux[2];
      eR = eL && !eP; aR = aL && !aP;
      idleNow = idleEnable && eL;
      blank = !altMode && auxMode == 2'd2 && aL;
      send = !idleNow && !blank;
      errNow = !idleEnable && (eR || mPend);
      mData = send ? (tbMem[mHalf * N + mPos] ^ errNow) : 1'b0;
      mIdle = idleNow;
      mPend = errNow && !send;
      len = (mHalf != 0) ? int'(lenB) : int'(lenA);
      if (mPos >= len - 1) begin
        mPos = 0;
        mHalf = altMode ? mTarget : 0;
      end else mPos++;
      if (altMode) begin
        if (auxMode == 2'd0 && aR) mTarget = 1 - mTarget;
        else if (auxMode == 2'd1) mTarget = aL;
      end
      qErr.push_front(errAddIn); void'(qErr.pop_back());
      qAux.push_front(auxIn);    void'(qAux.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      check(curReq, "dataOut", dataOut, mData);
      check(curReq, "idleOut", idleOut, mIdle);
      check(curReq, "activeHalf", activeHalf, mHalf[0]);
    end
  end

  task automatic ticks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic errPulse(int hi, int lo);
    errAddIn = 1'b1; ticks(hi);
    errAddIn = 1'b0; ticks(lo);
  endtask

  task automatic auxPulse(int hi, int lo);
    auxIn = 1'b1; ticks(hi);
    auxIn = 1'b0; ticks(lo);
  endtask

  initial begin
    for (int i = 0; i < 2 * N; i++) begin
      tbMem[i] = ((i * 7 + i / 3) % 3) == 0;
    end
    ticks(2);
    for (int i = 0; i < 2 * N; i++) begin
      wrEn = 1'b1; wrAddr = AW'(i); wrData = tbMem[i];
      ticks(1);
    end
    wrEn = 1'b0;
    // R1: reset state
    check("R1", "dataOut in reset", dataOut, 1'b0);
    check("R1", "idleOut in reset", idleOut, 1'b0);
    check("R1", "activeHalf in reset", activeHalf, 1'b0);
    rstN = 1'b1;
    curReq = "R2";
    ticks(3 * LEN_A + 7);

    curReq = "R7";
    errPulse(3, 6);
    errPulse(2, 9);
    errPulse(4, 3);

    curReq = "R6";
    auxMode = 2'd2;
    auxIn = 1'b1; ticks(6);
    curReq = "R8";
    errPulse(2, 4);
    auxIn = 1'b0; ticks(8);
    curReq = "R6";
    auxPulse(5, 7);

    curReq = "R3";
    auxMode = 2'd0;
    altMode = 1'b1;
    ticks(5);
    auxPulse(2, 20);
    curReq = "R5";
    auxPulse(1, 3);
    auxPulse(1, 20);
    curReq = "R3";
    auxPulse(3, 15);

    curReq = "R4";
    auxMode = 2'd1;
    auxIn = 1'b1; ticks(18);
    auxIn = 1'b0; ticks(3);
    auxIn = 1'b1; ticks(2);
    auxIn = 1'b0; ticks(20);
    auxIn = 1'b1; ticks(16);
    curReq = "R5";
    altMode = 1'b0; auxIn = 1'b0; ticks(20);

    curReq = "R9";
    idleEnable = 1'b1;
    ticks(4);
    errPulse(8, 6);
    errPulse(3, 5);

    // R10: latency of a level change, counted in rising edges
    curReq = "R10";
    errAddIn = 1'b1;
    @(negedge clk); check("R10", "idleOut after edge 1", idleOut, 1'b0);
    @(negedge clk); check("R10", "idleOut after edge 2", idleOut, 1'b0);
    @(negedge clk); check("R10", "idleOut after edge 3", idleOut, 1'b1);
    check("R9", "dataOut while idle", dataOut, 1'b0);
    errAddIn = 1'b0;
    ticks(6);
    check("R9", "idleOut released", idleOut, 1'b0);
    idleEnable = 1'b0;
    curReq = "R7";
    ticks(4);
    errPulse(2, 10);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4ns * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule